// File: doc/BRIEF.md
# Effective Address Translator with Segment Registers and Block Windows

This block converts a 32-bit effective address into one of two forms for the memory system. On the paged path, the four most significant address bits select one of sixteen segment registers. The virtual segment identifier held in that register is joined with the 16-bit page index taken from the address. The result is a 40-bit virtual page number for a downstream page lookup. The 12-bit byte offset within the 4 KB page passes through unchanged.

In parallel, the block checks two banks of four block windows each. One bank is used for instruction fetches and the other for data loads and stores. Each window has an enable bit, an effective base, a pass-through mask and a physical base, all at 4 KB granularity. When a window on the side selected by the request matches the address, the block produces a physical address directly and marks the result as bypassing paging.

Segment registers may only be loaded when the supervisor input is high. A load attempted without it changes nothing and raises an error pulse. Window registers have their own write port. Every request is answered exactly one clock later.

Top module: `ea_xlate`

## Requirements
- R1: After reset, `rsp_valid` and `seg_wr_err` are 0, every segment register holds 0 and every window is disabled, so a request is answered on the paged path with a segment identifier of 0.
- R2: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low.
- R3: When no window hits, `rsp_bypass` is 0 and `rsp_vpn` equals {segment register selected by `req_ea[31:28]`, `req_ea[27:12]`}, with the 24-bit identifier in bits 39:16.
- R4: `rsp_off` equals `req_ea[11:0]` of the request being answered, on both paths and for both fetch and data requests.
- R5: Window w hits when it is enabled and `(req_ea[31:12] & ~mask) == (ebase & ~mask)`. A mask bit of 1 marks an address bit that is not compared. A disabled window never hits.
- R6: On a hit, `rsp_bypass` is 1, `rsp_win` gives the window number, and `rsp_pa` equals {`(pbase & ~mask) | (req_ea[31:12] & mask)`, `req_ea[11:0]`}.
- R7: When several windows on the selected side hit, the lowest-numbered one supplies `rsp_win` and `rsp_pa`.
- R8: With `req_fetch` = 1, only the instruction bank (`bat_side` = 1) is compared. With `req_fetch` = 0, only the data bank (`bat_side` = 0) is compared.
- R9: A segment write with `sup_mode` = 0 leaves the register unchanged and makes `seg_wr_err` 1 for exactly the next cycle. In every other case, `seg_wr_err` is 0 in the next cycle.
- R10: A segment or window write takes effect for requests in later cycles. A request in the same cycle as the write sees the previous contents.
- R11: When `rsp_bypass` is 0, `rsp_pa` and `rsp_win` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ea | input | 32 | Effective address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| sup_mode | input | 1 | Supervisor privilege for segment writes |
| seg_we | input | 1 | Segment register write strobe |
| seg_sel | input | 4 | Segment register number to write |
| seg_vsid_in | input | 24 | Virtual segment identifier to write |
| bat_we | input | 1 | Window write strobe |
| bat_side | input | 1 | 1 = instruction bank, 0 = data bank |
| bat_sel | input | 2 | Window number within the bank |
| bat_ebase | input | 20 | Effective base, address bits 31:12 |
| bat_mask | input | 20 | Pass-through mask, 1 = bit not compared |
| bat_pbase | input | 20 | Physical base, address bits 31:12 |
| bat_en | input | 1 | Window enable |
| rsp_valid | output | 1 | Response present |
| rsp_bypass | output | 1 | Window hit; `rsp_pa` is valid |
| rsp_win | output | 2 | Number of the winning window |
| rsp_pa | output | 32 | Physical address on a window hit |
| rsp_vpn | output | 40 | Virtual page number for the page lookup |
| rsp_off | output | 12 | Byte offset within the page |
| seg_wr_err | output | 1 | Rejected segment write, one-cycle pulse |

## Verification
The assertions take for granted that inputs are stable through each rising edge and that `rst_n` is held low across at least one edge before the first request. They also assume no write strobe is left undriven. The priority checks take the hit vector of the bank selected by `req_fetch` as the reference, so the bench keeps `req_fetch` at a known level in every cycle, including idle ones. Stimulus is driven on falling edges and includes overlapping windows, a disabled window, writes in the same cycle as a request, and a segment write without privilege.

// File: rtl/ea_xlate_pkg.sv
package ea_xlate_pkg;
  localparam int EA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int SEL_W  = 4;
  localparam int HI_W   = EA_W - OFF_W;
  localparam int PG_W   = HI_W - SEL_W;
  localparam int VSID_W = 24;
  localparam int VPN_W  = VSID_W + PG_W;
  localparam int NSEG   = 1 << SEL_W;
  localparam int NWIN   = 4;
  localparam int WIN_W  = (NWIN > 1) ? $clog2(NWIN) : 1;

  typedef struct packed {
    logic            en;
    logic [HI_W-1:0] ebase;
    logic [HI_W-1:0] mask;
    logic [HI_W-1:0] pbase;
  } win_t;

  // A mask bit of 1 removes that address bit from the comparison.
  function automatic logic win_hit(input win_t w, input logic [HI_W-1:0] hi);
    return w.en && ((hi & ~w.mask) == (w.ebase & ~w.mask));
  endfunction

  // Upper bits come from the physical base, masked bits from the address.
  function automatic logic [HI_W-1:0] win_map(input win_t w, input logic [HI_W-1:0] hi);
    return (w.pbase & ~w.mask) | (hi & w.mask);
  endfunction

  function automatic logic [VPN_W-1:0] vpn_join(input logic [VSID_W-1:0] vsid,
                                                input logic [PG_W-1:0] pg);
    return {vsid, pg};
  endfunction
endpackage

// File: rtl/ea_seg_file.sv
module ea_seg_file
  import ea_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sup,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [VSID_W-1:0] wdata,
  input  logic [SEL_W-1:0]  rsel,
  output logic [VSID_W-1:0] rdata,
  output logic              wr_reject,
  output logic              err_q
);
  logic [VSID_W-1:0] regs [NSEG];
  logic              wr_accept;

  assign wr_reject = we & ~sup;
  assign wr_accept = we & sup;
  assign rdata     = regs[rsel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      for (int i = 0; i < NSEG; i++) regs[i] <= '0;
    end else begin
      err_q <= wr_reject;
      if (wr_accept) regs[wsel] <= wdata;
    end
  end
endmodule

// File: rtl/ea_low_pick.sv
module ea_low_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  // Two's complement isolates the lowest set bit.
  assign grant = req & ((~req) + N'(1));
  assign any   = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ea_win_bank.sv
module ea_win_bank
  import ea_xlate_pkg::*;
#(
  parameter int N  = NWIN,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   wsel,
  input  win_t            wdata,
  input  logic [HI_W-1:0] hi,
  output logic [N-1:0]    hit_vec,
  output logic [N-1:0]    grant,
  output logic [IW-1:0]   idx,
  output logic            any,
  output logic [HI_W-1:0] map_hi
);
  win_t            ent     [N];
  logic [HI_W-1:0] map_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent[g] <= '0;
      end else if (we && (wsel == IW'(g))) begin
        ent[g] <= wdata;
      end
    end
    assign hit_vec[g] = win_hit(ent[g], hi);
    assign map_arr[g] = win_map(ent[g], hi);
  end

  ea_low_pick #(.N(N)) u_pick (
    .req   (hit_vec),
    .grant (grant),
    .idx   (idx),
    .any   (any)
  );

  assign map_hi = map_arr[idx];
endmodule

// File: rtl/ea_xlate.sv
module ea_xlate
  import ea_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [EA_W-1:0]   req_ea,
  input  logic              req_fetch,
  input  logic              sup_mode,
  input  logic              seg_we,
  input  logic [SEL_W-1:0]  seg_sel,
  input  logic [VSID_W-1:0] seg_vsid_in,
  input  logic              bat_we,
  input  logic              bat_side,
  input  logic [WIN_W-1:0]  bat_sel,
  input  logic [HI_W-1:0]   bat_ebase,
  input  logic [HI_W-1:0]   bat_mask,
  input  logic [HI_W-1:0]   bat_pbase,
  input  logic              bat_en,
  output logic              rsp_valid,
  output logic              rsp_bypass,
  output logic [WIN_W-1:0]  rsp_win,
  output logic [EA_W-1:0]   rsp_pa,
  output logic [VPN_W-1:0]  rsp_vpn,
  output logic [OFF_W-1:0]  rsp_off,
  output logic              seg_wr_err
);
  logic [HI_W-1:0]   ea_hi;
  logic [SEL_W-1:0]  ea_seg;
  logic [PG_W-1:0]   ea_pg;
  logic [VSID_W-1:0] cur_vsid;
  logic              seg_wr_reject;
  win_t              wr_win;

  logic [NWIN-1:0]  i_hit, i_grant, d_hit, d_grant;
  logic [WIN_W-1:0] i_idx, d_idx;
  logic             i_any, d_any;
  logic [HI_W-1:0]  i_map, d_map;

  // Named events for the checker.
  logic [NWIN-1:0]  win_hit_vec, win_grant_vec;
  logic             sel_any;
  logic [WIN_W-1:0] sel_idx;
  logic [HI_W-1:0]  sel_map;
  logic             take_bypass;

  assign ea_hi  = req_ea[EA_W-1:OFF_W];
  assign ea_seg = req_ea[EA_W-1 -: SEL_W];
  assign ea_pg  = req_ea[OFF_W +: PG_W];

  assign wr_win = '{en: bat_en, ebase: bat_ebase, mask: bat_mask, pbase: bat_pbase};

  ea_seg_file u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (seg_we),
    .sup       (sup_mode),
    .wsel      (seg_sel),
    .wdata     (seg_vsid_in),
    .rsel      (ea_seg),
    .rdata     (cur_vsid),
    .wr_reject (seg_wr_reject),
    .err_q     (seg_wr_err)
  );

  ea_win_bank #(.N(NWIN)) u_ibank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bat_we & bat_side),
    .wsel    (bat_sel),
    .wdata   (wr_win),
    .hi      (ea_hi),
    .hit_vec (i_hit),
    .grant   (i_grant),
    .idx     (i_idx),
    .any     (i_any),
    .map_hi  (i_map)
  );

  ea_win_bank #(.N(NWIN)) u_dbank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bat_we & ~bat_side),
    .wsel    (bat_sel),
    .wdata   (wr_win),
    .hi      (ea_hi),
    .hit_vec (d_hit),
    .grant   (d_grant),
    .idx     (d_idx),
    .any     (d_any),
    .map_hi  (d_map)
  );

  assign win_hit_vec   = req_fetch ? i_hit   : d_hit;
  assign win_grant_vec = req_fetch ? i_grant : d_grant;
  assign sel_any       = req_fetch ? i_any   : d_any;
  assign sel_idx       = req_fetch ? i_idx   : d_idx;
  assign sel_map       = req_fetch ? i_map   : d_map;
  assign take_bypass   = req_valid & sel_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_bypass <= 1'b0;
      rsp_win    <= '0;
      rsp_pa     <= '0;
      rsp_vpn    <= '0;
      rsp_off    <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_bypass <= take_bypass;
      rsp_win    <= take_bypass ? sel_idx : '0;
      rsp_pa     <= take_bypass ? {sel_map, req_ea[OFF_W-1:0]} : '0;
      rsp_vpn    <= vpn_join(cur_vsid, ea_pg);
      rsp_off    <= req_ea[OFF_W-1:0];
    end
  end
endmodule

// File: rtl/ea_xlate_chk.sv
module ea_xlate_chk
  import ea_xlate_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [EA_W-1:0]  req_ea,
  input logic             seg_we,
  input logic             sup_mode,
  input logic             rsp_valid,
  input logic             rsp_bypass,
  input logic [WIN_W-1:0] rsp_win,
  input logic [EA_W-1:0]  rsp_pa,
  input logic [OFF_W-1:0] rsp_off,
  input logic             seg_wr_err,
  input logic [NWIN-1:0]  win_hit_vec,
  input logic [NWIN-1:0]  win_grant_vec
);
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_off == $past(req_ea[OFF_W-1:0])));
  a_r9_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_we && !sup_mode) |=> seg_wr_err);
  a_r9_flag_only_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    !(seg_we && !sup_mode) |=> !seg_wr_err);
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_grant_vec));
  a_r7_grant_within_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (win_grant_vec & ~win_hit_vec) == '0);
  a_r6_hit_gives_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (win_hit_vec != '0)) |=> rsp_bypass);
  a_r6_bypass_offset: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_bypass |-> (rsp_pa[OFF_W-1:0] == rsp_off) && rsp_valid);
  a_r11_paged_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_bypass |-> (rsp_pa == '0) && (rsp_win == '0));
endmodule

bind ea_xlate ea_xlate_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ea        (req_ea),
  .seg_we        (seg_we),
  .sup_mode      (sup_mode),
  .rsp_valid     (rsp_valid),
  .rsp_bypass    (rsp_bypass),
  .rsp_win       (rsp_win),
  .rsp_pa        (rsp_pa),
  .rsp_off       (rsp_off),
  .seg_wr_err    (seg_wr_err),
  .win_hit_vec   (win_hit_vec),
  .win_grant_vec (win_grant_vec)
);

// File: tb/ea_xlate_test.sv
module ea_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_fetch = 1'b0, sup_mode = 1'b0;
  logic [31:0] req_ea = '0;
  logic        seg_we = 1'b0;
  logic [3:0]  seg_sel = '0;
  logic [23:0] seg_vsid_in = '0;
  logic        bat_we = 1'b0, bat_side = 1'b0, bat_en = 1'b0;
  logic [1:0]  bat_sel = '0;
  logic [19:0] bat_ebase = '0, bat_mask = '0, bat_pbase = '0;
  logic        rsp_valid, rsp_bypass, seg_wr_err;
  logic [1:0]  rsp_win;
  logic [31:0] rsp_pa;
  logic [39:0] rsp_vpn;
  logic [11:0] rsp_off;

  ea_xlate uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Reference state: index 1 = instruction bank, 0 = data bank.
  logic [23:0] mseg [16];
  logic        m_en  [2][4];
  logic [19:0] m_eb  [2][4];
  logic [19:0] m_msk [2][4];
  logic [19:0] m_pb  [2][4];

  typedef struct {
    time         due;
    logic        v, err, byp;
    logic [1:0]  win;
    logic [31:0] pa;
    logic [39:0] vpn;
    logic [11:0] off;
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input string tag, input string fld,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, fld, act, exp);
    end
  endtask

  // Driver: predicts the response, queues it, applies writes to the model.
  task automatic step(input logic v, input logic [31:0] ea, input logic f, input string tag);
    exp_t e;
    logic hit = 1'b0;
    logic [1:0] w = '0;
    logic [19:0] ph = '0;
    logic [19:0] hi = ea[31:12];
    int s = f ? 1 : 0;
    req_valid = v; req_ea = ea; req_fetch = f;
    for (int i = 0; i < 4; i++) begin
      if (!hit && m_en[s][i] && (((hi ^ m_eb[s][i]) & ~m_msk[s][i]) == 20'h0)) begin
        hit = 1'b1;
        w   = 2'(i);
        ph  = m_pb[s][i] ^ ((m_pb[s][i] ^ hi) & m_msk[s][i]);
      end
    end
    e.due = $time + 10;
    e.v   = v;
    e.err = seg_we && !sup_mode;
    e.byp = v && hit;
    e.win = e.byp ? w : 2'd0;
    e.pa  = e.byp ? {ph, ea[11:0]} : 32'h0;
    e.vpn = {mseg[ea[31:28]], ea[27:12]};
    e.off = ea[11:0];
    e.tag = tag;
    sb.push_back(e);
    if (seg_we && sup_mode) mseg[seg_sel] = seg_vsid_in;
    if (bat_we) begin
      m_en[bat_side][bat_sel]  = bat_en;
      m_eb[bat_side][bat_sel]  = bat_ebase;
      m_msk[bat_side][bat_sel] = bat_mask;
      m_pb[bat_side][bat_sel]  = bat_pbase;
    end
    @(negedge clk);
    seg_we = 1'b0; bat_we = 1'b0; req_valid = 1'b0;
  endtask

  task automatic put_win(input logic side, input logic [1:0] sel, input logic en,
                         input logic [19:0] eb, input logic [19:0] mk, input logic [19:0] pb);
    bat_we = 1'b1; bat_side = side; bat_sel = sel; bat_en = en;
    bat_ebase = eb; bat_mask = mk; bat_pbase = pb;
  endtask

  // Monitor: pops the item due at this falling edge and compares.
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == $time) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "valid R2", 64'(rsp_valid), 64'(e.v));
      chk(e.tag, "err R9", 64'(seg_wr_err), 64'(e.err));
      chk(e.tag, "bypass", 64'(rsp_bypass), 64'(e.byp));
      if (e.v) begin
        chk(e.tag, "vpn", 64'(rsp_vpn), 64'(e.vpn));
        chk(e.tag, "off R4", 64'(rsp_off), 64'(e.off));
        chk(e.tag, "win", 64'(rsp_win), 64'(e.win));
        chk(e.tag, "pa", 64'(rsp_pa), 64'(e.pa));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mseg[i] = '0;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 4; i++) begin
        m_en[s][i] = 1'b0; m_eb[s][i] = '0; m_msk[s][i] = '0; m_pb[s][i] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'h0);
    chk("R1", "seg_wr_err", 64'(seg_wr_err), 64'h0);
    step(1'b1, 32'h3ABC_D123, 1'b0, "R1");
    step(1'b1, 32'h9000_0FFF, 1'b1, "R1");

    // Load all segment registers with privilege.
    for (int k = 0; k < 16; k++) begin
      seg_we = 1'b1; sup_mode = 1'b1; seg_sel = 4'(k);
      seg_vsid_in = 24'h5A0000 ^ (24'(k) * 24'h0001F3);
      step(1'b0, 32'h0, 1'b0, "R10");
    end
    step(1'b1, 32'h0123_4567, 1'b0, "R3");
    step(1'b0, 32'h0, 1'b0, "R2");
    step(1'b1, 32'h7FED_C000, 1'b0, "R3");
    step(1'b1, 32'hF000_1ABC, 1'b1, "R4");
    step(1'b0, 32'h0, 1'b1, "R2");
    step(1'b1, 32'h3FFF_FFFF, 1'b0, "R3");

    // Unprivileged write is refused.
    seg_we = 1'b1; sup_mode = 1'b0; seg_sel = 4'd5; seg_vsid_in = 24'hDEAD00;
    step(1'b0, 32'h0, 1'b0, "R9");
    step(1'b1, 32'h5000_1000, 1'b0, "R9");

    // Privileged write alongside a request to the same segment.
    seg_we = 1'b1; sup_mode = 1'b1; seg_sel = 4'd6; seg_vsid_in = 24'hC0FFEE;
    step(1'b1, 32'h6123_4567, 1'b0, "R10");
    step(1'b1, 32'h6123_4567, 1'b0, "R10");

    // Data window 2: 4 MB region.
    put_win(1'b0, 2'd2, 1'b1, 20'h40000, 20'h003FF, 20'h80000);
    step(1'b1, 32'h4012_3456, 1'b0, "R10");
    step(1'b1, 32'h4012_3456, 1'b0, "R6");
    step(1'b1, 32'h4012_3456, 1'b1, "R8");
    step(1'b1, 32'h4412_3456, 1'b0, "R5");
    step(1'b1, 32'h403F_FFFF, 1'b0, "R6");

    // Overlapping instruction windows 1 (wide) and 0 (narrow).
    put_win(1'b1, 2'd1, 1'b1, 20'h10000, 20'h0FFFF, 20'h20000);
    step(1'b0, 32'h0, 1'b1, "R10");
    put_win(1'b1, 2'd0, 1'b1, 20'h10000, 20'h000FF, 20'h30000);
    step(1'b0, 32'h0, 1'b1, "R10");
    step(1'b1, 32'h1000_0ABC, 1'b1, "R7");
    step(1'b1, 32'h1050_0000, 1'b1, "R7");
    step(1'b1, 32'h1000_0ABC, 1'b0, "R8");

    // Disable window 0; window 1 then answers.
    put_win(1'b1, 2'd0, 1'b0, 20'h10000, 20'h000FF, 20'h30000);
    step(1'b1, 32'h1000_0ABC, 1'b1, "R10");
    step(1'b1, 32'h1000_0ABC, 1'b1, "R5");
    step(1'b1, 32'h2000_0000, 1'b1, "R11");
    step(1'b0, 32'h0, 1'b0, "R2");
    step(1'b0, 32'h0, 1'b0, "R2");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule